// File: doc/BRIEF.md
# Descriptor Ring Prefetch and Writeback Controller

This block keeps a small on-chip cache of 16-byte DMA descriptors that live in a ring in host memory. Software sets the ring base address, its length in bytes and the tail index. The block owns the head index. Software can load the head through a configuration strobe, which also empties the cache. On request, the block reads ahead as many descriptors as the ring and the free cache slots allow. It hands cached descriptors one at a time to a consumer through a consume strobe.

When asked to write back, the block returns the used descriptors in one burst write and then advances the head. The burst length can be trimmed to an alignment mask, and it is always cut at the ring end. A follow-up burst is scheduled when the first one could not cover everything. The DMA engine sits outside the block. It sees one request channel (address, count, direction) with a valid/ready handshake. It reports completion on a separate strobe for reads and for writes.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset the head index is 0, the used and unused counts are 0, no DMA request is valid, and both error pulses are low.
- R2: The ring length in descriptors is `ring_bytes >> 4`. A prefetch reads from `ring_base + 16*cptr`, where cptr is the internal cache pointer. The count is `tail - cptr` when tail >= cptr, otherwise `len - cptr`, so a burst never crosses the wrap. That count is then limited to the free slots, which are DEPTH minus the used and unused entries.
- R3: Only one prefetch is in flight at a time. A fetch request while one is pending is ignored, and a computed count of zero issues nothing.
- R4: On read completion the unused count grows by the burst count. The cache pointer advances by the same amount and wraps to 0 when it equals the ring length.
- R5: A consume strobe moves one entry from unused to used. With no unused entry, it raises `consume_err` on the next cycle and changes no count.
- R6: A writeback writes to `ring_base + 16*head`. Its base count is the used count. If head plus that count is at least the ring length, the count becomes `len - head` and a follow-up is armed. Otherwise, with a nonzero mask, the count is `used & ~mask`. A count of zero issues nothing.
- R7: A writeback request made while a writeback is pending issues nothing. If its mask is smaller than the stored mask, that mask is kept and a follow-up is armed.
- R8: On write completion the used count drops by the burst count, and the head advances by it modulo the ring length. An armed follow-up writeback is issued next with the stored mask, and a prefetch is also attempted.
- R9: A configuration strobe loads the head, clears the cache and sets the cache pointer to 0. This happens only when no used entry, no prefetch and no writeback exists. Otherwise it raises `cfg_err` and changes nothing.
- R10: `desc_left` equals the unused count plus the absolute difference between the cache pointer and the tail.
- R11: A valid request holds its address, count and direction until accepted. When a write and a read are both pending and none is being presented, the write goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Ring base byte address |
| ring_bytes | input | IDX_W+4 | Ring length in bytes |
| ring_tail | input | IDX_W | Software tail index |
| cfg_we | input | 1 | Load head and reset the cache |
| cfg_head | input | IDX_W | Head value for cfg_we |
| fetch_req | input | 1 | Request a prefetch |
| consume | input | 1 | Take one cached descriptor |
| wb_req | input | 1 | Request a writeback |
| wb_mask | input | CNT_W | Alignment mask for the writeback |
| dma_req_valid | output | 1 | DMA request valid |
| dma_req_ready | input | 1 | DMA request accepted |
| dma_req_addr | output | ADDR_W | Burst start address |
| dma_req_count | output | CNT_W | Descriptors in the burst |
| dma_req_write | output | 1 | 1 for writeback, 0 for prefetch |
| dma_rd_done | input | 1 | Prefetch burst completed |
| dma_wr_done | input | 1 | Writeback burst completed |
| ring_head | output | IDX_W | Current head index |
| used_cnt | output | CNT_W | Consumed, not yet written back |
| unused_cnt | output | CNT_W | Cached, not yet consumed |
| desc_left | output | IDX_W+1 | Unused plus pointer-to-tail distance |
| consume_err | output | 1 | Pulse: consume with empty cache |
| cfg_err | output | 1 | Pulse: config change while busy |

## Verification
Prefetch is tried with the tail ahead of the cache pointer, with the tail behind it so the burst stops at the ring end, and with the cache full so the free-slot limit or a zero count decides. Each of these picks out a different branch of the count rule. Writeback is tried with no mask, with a mask that trims the count, with a request that arrives mid-burst carrying a smaller mask, and with a burst that crosses the ring end. These cases separate plain issue, alignment trim, deferred follow-up and wrap follow-up. The order in which the follow-up write and the automatic prefetch reach the request port shows the write-first rule. A stalled ready shows that the request is held.

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [IDX_W+3:0]  ring_bytes,
  input  logic [IDX_W-1:0]  ring_tail,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_head,
  input  logic              fetch_req,
  input  logic              consume,
  input  logic              wb_req,
  input  logic [CNT_W-1:0]  wb_mask,
  output logic              dma_req_valid,
  input  logic              dma_req_ready,
  output logic [ADDR_W-1:0] dma_req_addr,
  output logic [CNT_W-1:0]  dma_req_count,
  output logic              dma_req_write,
  input  logic              dma_rd_done,
  input  logic              dma_wr_done,
  output logic [IDX_W-1:0]  ring_head,
  output logic [CNT_W-1:0]  used_cnt,
  output logic [CNT_W-1:0]  unused_cnt,
  output logic [IDX_W:0]    desc_left,
  output logic              consume_err,
  output logic              cfg_err
);

  logic [IDX_W-1:0]  head, cptr;
  logic [CNT_W-1:0]  used, unused;
  logic              f_req, f_wait, w_req, w_wait;
  logic [ADDR_W-1:0] f_addr, w_addr;
  logic [CNT_W-1:0]  f_cnt, w_cnt, mask_q;
  logic              follow, wb_retry, fetch_retry;
  logic              lock_q, lock_w_q;

  wire [31:0] len32  = 32'(ring_bytes[IDX_W+3:4]);
  wire        f_busy = f_req | f_wait;
  wire        w_busy = w_req | w_wait;
  wire        cfg_ok = cfg_we && used == '0 && !f_busy && !w_busy;
  wire        cons_ok = consume && unused != '0;
  wire        sel_w  = lock_q ? lock_w_q : w_req;
  wire        accept = dma_req_valid && dma_req_ready;

  logic [31:0]      span, free_s, fcnt32, wcnt32;
  logic             wwrap;
  logic [CNT_W-1:0] mask_eff;

  always_comb begin
    span   = (32'(ring_tail) >= 32'(cptr)) ? 32'(ring_tail) - 32'(cptr) : len32 - 32'(cptr);
    free_s = 32'(DEPTH) - 32'(used) - 32'(unused);
    fcnt32 = (span < free_s) ? span : free_s;
    if (wb_retry)
      mask_eff = (wb_req && wb_mask < mask_q) ? wb_mask : mask_q;
    else
      mask_eff = wb_mask;
    wwrap = (32'(head) + 32'(used)) >= len32;
    if (wwrap)               wcnt32 = len32 - 32'(head);
    else if (mask_eff != '0) wcnt32 = 32'(used & ~mask_eff);
    else                     wcnt32 = 32'(used);
  end

  wire fetch_go = (fetch_req | fetch_retry) && !f_busy && !cfg_we && fcnt32 != 0;
  wire wb_go    = (wb_req | wb_retry) && !w_busy && !cfg_we;

  assign dma_req_valid = f_req | w_req;
  assign dma_req_write = sel_w;
  assign dma_req_addr  = sel_w ? w_addr : f_addr;
  assign dma_req_count = sel_w ? w_cnt : f_cnt;
  assign ring_head  = head;
  assign used_cnt   = used;
  assign unused_cnt = unused;
  assign desc_left  = (IDX_W+1)'(unused) +
                      ((cptr >= ring_tail) ? (IDX_W+1)'(cptr - ring_tail) : (IDX_W+1)'(ring_tail - cptr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0; cptr <= '0; used <= '0; unused <= '0;
      f_req <= 1'b0; f_wait <= 1'b0; w_req <= 1'b0; w_wait <= 1'b0;
      f_addr <= '0; w_addr <= '0; f_cnt <= '0; w_cnt <= '0; mask_q <= '0;
      follow <= 1'b0; wb_retry <= 1'b0; fetch_retry <= 1'b0;
      lock_q <= 1'b0; lock_w_q <= 1'b0; consume_err <= 1'b0; cfg_err <= 1'b0;
    end else begin
      consume_err <= consume && unused == '0;
      cfg_err     <= cfg_we && !cfg_ok;
      wb_retry    <= 1'b0;
      fetch_retry <= 1'b0;
      lock_q      <= dma_req_valid && !dma_req_ready;
      lock_w_q    <= sel_w;

      used   <= used + CNT_W'(cons_ok) - (dma_wr_done && w_wait ? w_cnt : '0);
      unused <= unused - CNT_W'(cons_ok) + (dma_rd_done && f_wait ? f_cnt : '0);

      if (fetch_go) begin
        f_req  <= 1'b1;
        f_cnt  <= CNT_W'(fcnt32);
        f_addr <= ring_base + ADDR_W'({cptr, 4'b0000});
      end else if (accept && !sel_w) begin
        f_req <= 1'b0; f_wait <= 1'b1;
      end else if (dma_rd_done && f_wait) begin
        f_wait <= 1'b0;
        if (32'(cptr) + 32'(f_cnt) >= len32) cptr <= '0;
        else cptr <= cptr + IDX_W'(f_cnt);
      end

      if (wb_go) begin
        mask_q <= mask_eff;
        follow <= wwrap;
        if (wcnt32 != 0) begin
          w_req  <= 1'b1;
          w_cnt  <= CNT_W'(wcnt32);
          w_addr <= ring_base + ADDR_W'({head, 4'b0000});
        end
      end else if (wb_req && w_busy && wb_mask < mask_q) begin
        mask_q <= wb_mask;
        follow <= 1'b1;
      end
      if (accept && sel_w) begin
        w_req <= 1'b0; w_wait <= 1'b1;
      end else if (dma_wr_done && w_wait) begin
        w_wait      <= 1'b0;
        wb_retry    <= follow;
        follow      <= 1'b0;
        fetch_retry <= 1'b1;
        if (32'(head) + 32'(w_cnt) >= len32) head <= IDX_W'(32'(head) + 32'(w_cnt) - len32);
        else head <= head + IDX_W'(w_cnt);
      end

      if (cfg_ok) begin
        head <= cfg_head; cptr <= '0; unused <= '0;
      end
    end
  end

  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(used) + 32'(unused) <= 32'(DEPTH));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_valid && !dma_req_ready |=> dma_req_valid && $stable(dma_req_addr)
      && $stable(dma_req_count) && $stable(dma_req_write));
  p_nowrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    f_req |-> f_cnt != '0 && 32'(cptr) + 32'(f_cnt) <= len32);
  p_wb_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    w_req |-> w_cnt != '0 && 32'(head) + 32'(w_cnt) <= len32);
  p_cons_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    consume && unused == '0 |=> consume_err);
  p_cfg_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (used != '0 || f_busy || w_busy) |=> cfg_err);
  p_one_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    f_wait |-> !f_req);

endmodule

// File: tb/desc_ring_ctrl_bench.sv
module desc_ring_ctrl_bench;
  localparam int AW = 16, IW = 4, DP = 4, CW = 3;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] ring_base = 16'h1000;
  logic [IW+3:0] ring_bytes = 8'd160;
  logic [IW-1:0] ring_tail = 0, cfg_head = 0;
  logic cfg_we = 0, fetch_req = 0, consume = 0, wb_req = 0, ready = 1, rd_done = 0, wr_done = 0;
  logic [CW-1:0] wb_mask = 0;
  logic valid, wr, consume_err, cfg_err;
  logic [AW-1:0] addr;
  logic [CW-1:0] cnt, used, unused;
  logic [IW-1:0] head;
  logic [IW:0] left;
  int tests = 0, fails = 0;
  logic [AW+CW:0] expq[$];

  always #10 clk = ~clk;

  desc_ring_ctrl #(.ADDR_W(AW), .IDX_W(IW), .DEPTH(DP)) u_desc_ring_ctrl (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_bytes(ring_bytes),
    .ring_tail(ring_tail), .cfg_we(cfg_we), .cfg_head(cfg_head), .fetch_req(fetch_req),
    .consume(consume), .wb_req(wb_req), .wb_mask(wb_mask), .dma_req_valid(valid),
    .dma_req_ready(ready), .dma_req_addr(addr), .dma_req_count(cnt), .dma_req_write(wr),
    .dma_rd_done(rd_done), .dma_wr_done(wr_done), .ring_head(head), .used_cnt(used),
    .unused_cnt(unused), .desc_left(left), .consume_err(consume_err), .cfg_err(cfg_err));

  task automatic chk(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && valid && ready) begin
    tests++;
    if (expq.size() == 0) begin
      fails++;
      $display("FAIL R3/R6: unexpected request addr=%h cnt=%0d wr=%0b expected none", addr, cnt, wr);
    end else begin
      logic [AW+CW:0] e;
      e = expq.pop_front();
      if (e != {wr, cnt, addr}) begin
        fails++;
        $display("FAIL R2/R6/R11: request %h expected %h", {wr, cnt, addr}, e);
      end
    end
  end

  task automatic expect_req(int a, int c, bit w);
    expq.push_back({w, CW'(c), AW'(a)});
  endtask
  task automatic settle(); repeat (4) @(negedge clk); endtask
  task automatic do_fetch(); @(negedge clk) fetch_req = 1; @(negedge clk) fetch_req = 0; endtask
  task automatic do_consume(); @(negedge clk) consume = 1; @(negedge clk) consume = 0; endtask
  task automatic do_wb(int m); @(negedge clk) begin wb_req = 1; wb_mask = CW'(m); end @(negedge clk) wb_req = 0; endtask
  task automatic do_cfg(int h); @(negedge clk) begin cfg_we = 1; cfg_head = IW'(h); end @(negedge clk) cfg_we = 0; endtask
  task automatic do_rd(); @(negedge clk) rd_done = 1; @(negedge clk) rd_done = 0; endtask
  task automatic do_wr(); @(negedge clk) wr_done = 1; @(negedge clk) wr_done = 0; endtask

  task automatic finish_run();
    chk("R3 queue drained", expq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 head", head, 0); chk("R1 used", used, 0); chk("R1 unused", unused, 0);
    chk("R1 valid", valid, 0); chk("R1 cerr", consume_err, 0); chk("R1 cfgerr", cfg_err, 0);

    do_cfg(0);
    ring_tail = 3;
    @(negedge clk);
    chk("R10 left", left, 3);
    expect_req(16'h1000, 3, 0);
    do_fetch(); settle();
    do_fetch(); settle();             // R3 second request ignored while in flight
    do_rd(); settle();
    chk("R4 unused", unused, 3); chk("R10 left after fill", left, 3);

    ring_tail = 9;
    expect_req(16'h1030, 1, 0);       // R2 limited by free slots
    do_fetch(); settle(); do_rd(); settle();
    chk("R4 unused full", unused, 4);
    do_fetch(); settle();
    chk("R3 zero count no request", valid, 0);

    repeat (4) do_consume();
    chk("R5 used", used, 4); chk("R5 unused", unused, 0);
    do_consume();
    chk("R5 consume_err", consume_err, 1); chk("R5 used unchanged", used, 4);

    expect_req(16'h1000, 4, 1);
    do_wb(0); settle();
    expect_req(16'h1040, 4, 0);       // R8 prefetch after writeback
    do_wr(); settle();
    chk("R8 head", head, 4); chk("R8 used", used, 0);
    do_rd(); settle();
    chk("R4 unused", unused, 4);

    repeat (3) do_consume();
    expect_req(16'h1040, 2, 1);       // R6 mask trim 3 & ~1
    do_wb(1); settle();
    do_wb(0); settle();               // R7 deferred, smaller mask
    expect_req(16'h1060, 1, 1);       // R11 write before read
    expect_req(16'h1080, 1, 0);
    do_wr(); settle();
    chk("R8 head partial", head, 6);
    do_wr(); settle(); do_rd(); settle();
    chk("R8 head follow", head, 7); chk("R8 used zero", used, 0); chk("R4 unused two", unused, 2);

    ring_tail = 2;
    expect_req(16'h1090, 1, 0);       // R2 stop at ring end
    do_fetch(); settle(); do_rd(); settle();
    expect_req(16'h1000, 1, 0);       // R4 pointer wrapped to 0
    do_fetch(); settle(); do_rd(); settle();
    chk("R10 left wrap", left, 5);
    repeat (4) do_consume();
    expect_req(16'h1070, 3, 1);       // R6 cut at ring end
    do_wb(0); settle();
    expect_req(16'h1000, 1, 1);
    expect_req(16'h1010, 1, 0);
    do_wr(); settle();
    chk("R8 head wrap", head, 0);
    do_rd(); settle(); do_wr(); settle();
    chk("R8 head after follow", head, 1); chk("R3 idle", valid, 0); chk("R4 unused", unused, 1);

    do_consume();
    do_cfg(5);
    chk("R9 cfg_err", cfg_err, 1); chk("R9 head kept", head, 1);
    expect_req(16'h1010, 1, 1);
    do_wb(0); settle(); do_wr(); settle();
    chk("R8 head", head, 2);
    do_cfg(5);
    chk("R9 no err", cfg_err, 0); chk("R9 head load", head, 5); chk("R10 left reset", left, 2);

    ready = 0;
    expect_req(16'h1000, 2, 0);
    do_fetch();
    repeat (3) @(negedge clk);
    chk("R11 valid held", valid, 1); chk("R11 addr held", addr, 16'h1000); chk("R11 cnt held", cnt, 2);
    ready = 1;
    settle(); do_rd(); settle();
    chk("R4 unused final", unused, 2);
    finish_run();
  end
endmodule